// File: doc/BRIEF.md
# Dual-Scaling Fixed-Point Adder

This block adds two words in a dual-scaling fixed-point format and returns their sum in the same format. Each 16-bit word has one range-select bit at the top and a 15-bit two's complement significand below it. When the range bit is clear, the word is a fine-grained value with 14 fraction bits. When it is set, the word is a coarse value with 9 fraction bits. The coarse form trades 5 bits of precision for 32 times the span.

Both operands are first brought to the fine scale. The adder then forms the exact sum at full width. Only after that does it pick the output range. The fine range is preferred whenever the sum fits in it. Otherwise the sum is shifted down to the coarse scale, either truncated or rounded. The block flags any discarded nonzero bits, and it saturates and flags any sum too large for the coarse range. The result is registered.

A small state machine holds what kind of result is on the output. Its states are:

- `ST_IDLE`: no new result.
- `ST_LOW`: exact fine-range result.
- `ST_HIGH_EXACT`: coarse result with no bits lost.
- `ST_HIGH_CUT`: coarse result with nonzero bits discarded.
- `ST_SAT`: coarse result clamped to a limit.

State transitions work as follows:

- Every clock without `in_valid` moves the machine to `ST_IDLE`.
- Every clock with `in_valid` moves it to the state that matches the new sum, whatever the current state is. The order of checks is: fits the fine range → `ST_LOW`; beyond the coarse range → `ST_SAT`; discarded bits nonzero → `ST_HIGH_CUT`; otherwise → `ST_HIGH_EXACT`.

Top module: `dfx_adder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `result`, `trunc_flag` and `ovf_flag` are all 0.
- R2: A sum launched with `in_valid` high at one rising edge appears on the outputs after that same edge, with `out_valid` high for exactly one cycle. With `in_valid` low, `out_valid` is 0 and `result` keeps its value.
- R3: Word encoding: bit 15 is the range bit (0 = fine, value = sig·2^-14; 1 = coarse, value = sig·2^-9), and bits 14:0 hold the signed significand `sig`. A coarse operand counts as `sig`·32 at the fine scale.
- R4: If the aligned sum S lies in [-16384, 16383], the result has bit 15 = 0, bits 14:0 = S, and `trunc_flag` = `ovf_flag` = 0.
- R5: Otherwise the result has bit 15 = 1. With `round_en` = 0, its significand is floor(S/32), and `trunc_flag` is 1 exactly when S mod 32 ≠ 0.
- R6: When both operands are coarse, `trunc_flag` is never set.
- R7: With `round_en` = 1, a coarse result with S mod 32 ≥ 16 gets floor(S/32)+1. `trunc_flag` still reports S mod 32 ≠ 0.
- R8: Rounding is skipped when floor(S/32) is already 16383, so the result stays 16383 and `ovf_flag` stays 0.
- R9: If floor(S/32) is above 16383 or below -16384, the result is coarse 16383 or coarse -16384 respectively. In that case `ovf_flag` = 1 and `trunc_flag` = 0.
- R10: The range boundary is exact: S = 16383 gives a fine result and S = 16384 gives a coarse result (significand 512).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 16 | First operand word |
| op_b | input | 16 | Second operand word |
| round_en | input | 1 | 1 = round to nearest on coarse conversion, 0 = truncate |
| out_valid | output | 1 | New result on `result` |
| result | output | 16 | Sum word |
| trunc_flag | output | 1 | Nonzero bits were discarded |
| ovf_flag | output | 1 | Sum clamped at a coarse-range limit |

## Verification
The round-up step and the coarse upper limit can act on the same sum. This happens when the floored value is already 16383 and the round bit is set. It is provoked with a coarse 16383 plus a fine 16, and the result must stay 16383 with `trunc_flag` set and `ovf_flag` clear. The neighbouring pair, coarse 16383 plus coarse 1, must instead clamp with `ovf_flag` set and `trunc_flag` clear. This shows that saturation and quantisation reporting exclude each other, and negative sums are probed the same way at the lower limit.

// File: rtl/dfx_add_pkg.sv
package dfx_add_pkg;

    // Kind of result currently held on the outputs
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH_EXACT,
        ST_HIGH_CUT,
        ST_SAT
    } res_state_e;

endpackage

// File: rtl/dfx_align.sv
// Brings one operand word to the fine binary point.
module dfx_align #(
    parameter int WORD_W = 16,
    parameter int SHIFT  = 5,
    localparam int SIG_W = WORD_W - 1,
    localparam int ALN_W = SIG_W + SHIFT
) (
    input  logic [WORD_W-1:0] word,
    output logic [ALN_W-1:0]  aligned
);
    logic [SIG_W-1:0] sig;

    always_comb begin
        sig = word[SIG_W-1:0];
        if (word[WORD_W-1]) begin
            aligned = {sig, {SHIFT{1'b0}}};
        end else begin
            aligned = {{SHIFT{sig[SIG_W-1]}}, sig};
        end
    end
endmodule

// File: rtl/dfx_range_sel.sv
// Picks the output range for a full-width sum, then quantises and clamps it.
module dfx_range_sel #(
    parameter int WORD_W = 16,
    parameter int SHIFT  = 5,
    localparam int SIG_W = WORD_W - 1,
    localparam int SUM_W = SIG_W + SHIFT + 1,
    localparam int Q_W   = SUM_W - SHIFT
) (
    input  logic [SUM_W-1:0]  sum,
    input  logic              round_en,
    output logic [WORD_W-1:0] word,
    output logic              fits_low,
    output logic              cut,
    output logic              sat
);
    localparam logic [SIG_W-1:0] SIG_MAX = {1'b0, {(SIG_W-1){1'b1}}};
    localparam logic [SIG_W-1:0] SIG_MIN = {1'b1, {(SIG_W-1){1'b0}}};

    logic [SUM_W-SIG_W:0] upper;
    logic [Q_W-1:0]       q;
    logic [Q_W-SIG_W:0]   q_upper;
    logic [SHIFT-1:0]     rem;
    logic                 q_fits;
    logic                 at_max;
    logic                 bump;
    logic [SIG_W-1:0]     rounded;

    always_comb begin
        upper    = sum[SUM_W-1:SIG_W-1];
        fits_low = (&upper) | ~(|upper);
        q        = sum[SUM_W-1:SHIFT];
        rem      = sum[SHIFT-1:0];
        q_upper  = q[Q_W-1:SIG_W-1];
        q_fits   = (&q_upper) | ~(|q_upper);
        at_max   = (q[SIG_W-1:0] == SIG_MAX);
        bump     = round_en & rem[SHIFT-1] & ~at_max;
        rounded  = q[SIG_W-1:0] + {{(SIG_W-1){1'b0}}, bump};
        sat      = ~fits_low & ~q_fits;
        cut      = ~fits_low & q_fits & (|rem);
        if (fits_low) begin
            word = {1'b0, sum[SIG_W-1:0]};
        end else if (!q_fits) begin
            word = {1'b1, (q[Q_W-1] ? SIG_MIN : SIG_MAX)};
        end else begin
            word = {1'b1, rounded};
        end
    end
endmodule

// File: rtl/dfx_adder.sv
module dfx_adder #(
    parameter int WORD_W   = 16,
    parameter int FRAC_LO  = 14,
    parameter int FRAC_HI  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              round_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              trunc_flag,
    output logic              ovf_flag
);
    import dfx_add_pkg::*;

    localparam int SHIFT = FRAC_LO - FRAC_HI;
    localparam int SIG_W = WORD_W - 1;
    localparam int ALN_W = SIG_W + SHIFT;
    localparam int SUM_W = ALN_W + 1;
    localparam int N_OPS = 2;

    logic [N_OPS-1:0][WORD_W-1:0] ops;
    logic [N_OPS-1:0][ALN_W-1:0]  aligned;
    logic [SUM_W-1:0]             sum;
    logic [WORD_W-1:0]            word_d;
    logic                         fits_low, cut, sat;
    res_state_e                   state_q, state_d;
    logic [WORD_W-1:0]            result_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_align
        dfx_align #(.WORD_W(WORD_W), .SHIFT(SHIFT)) u_align (
            .word    (ops[g]),
            .aligned (aligned[g])
        );
    end

    assign sum = {aligned[0][ALN_W-1], aligned[0]} + {aligned[1][ALN_W-1], aligned[1]};

    dfx_range_sel #(.WORD_W(WORD_W), .SHIFT(SHIFT)) u_sel (
        .sum      (sum),
        .round_en (round_en),
        .word     (word_d),
        .fits_low (fits_low),
        .cut      (cut),
        .sat      (sat)
    );

    // Next state: classification of the sum being launched
    always_comb begin
        if (!in_valid)     state_d = ST_IDLE;
        else if (fits_low) state_d = ST_LOW;
        else if (sat)      state_d = ST_SAT;
        else if (cut)      state_d = ST_HIGH_CUT;
        else               state_d = ST_HIGH_EXACT;
    end

    // State register and held result word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) result_q <= word_d;
        end
    end

    // Output decode
    always_comb begin
        out_valid  = 1'b0;
        trunc_flag = 1'b0;
        ovf_flag   = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_LOW:        out_valid = 1'b1;
            ST_HIGH_EXACT: out_valid = 1'b1;
            ST_HIGH_CUT: begin
                out_valid  = 1'b1;
                trunc_flag = 1'b1;
            end
            ST_SAT: begin
                out_valid = 1'b1;
                ovf_flag  = 1'b1;
            end
            default:       ;
        endcase
    end

    assign result = result_q;
endmodule

// File: rtl/dfx_adder_chk.sv
module dfx_adder_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              a_exp,
    input logic              b_exp,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              trunc_flag,
    input logic              ovf_flag
);
    localparam int SIG_W = WORD_W - 1;
    localparam logic [SIG_W-1:0] SIG_MAX = {1'b0, {(SIG_W-1){1'b1}}};
    localparam logic [SIG_W-1:0] SIG_MIN = {1'b1, {(SIG_W-1){1'b0}}};

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    assert_fine_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !result[WORD_W-1]) |-> (!trunc_flag && !ovf_flag));
    assert_coarse_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_exp && b_exp) |=> !trunc_flag);
    assert_fine_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !a_exp && !b_exp) |=> !ovf_flag);
    assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (result[WORD_W-1] && !trunc_flag &&
                      (result[SIG_W-1:0] == SIG_MAX || result[SIG_W-1:0] == SIG_MIN)));
endmodule

bind dfx_adder dfx_adder_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .a_exp      (op_a[WORD_W-1]),
    .b_exp      (op_b[WORD_W-1]),
    .out_valid  (out_valid),
    .result     (result),
    .trunc_flag (trunc_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/dfx_adder_bench.sv
`timescale 1ns/1ps
module dfx_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        round_en = 1'b0;
    logic        out_valid;
    logic [15:0] result;
    logic        trunc_flag;
    logic        ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dfx_adder u_dfx_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .round_en(round_en), .out_valid(out_valid), .result(result),
        .trunc_flag(trunc_flag), .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] mk(input bit e, input int sig);
        logic [14:0] s;
        s = 15'(sig);
        return {e, s};
    endfunction

    function automatic int val(input logic [15:0] w);
        int s;
        s = int'(signed'(w[14:0]));
        return w[15] ? s * 32 : s;
    endfunction

    // Expected behaviour from the requirements
    function automatic void model(input logic [15:0] a, input logic [15:0] b, input bit rnd,
                                  output logic [15:0] w, output bit tr, output bit ov);
        int s, q, r;
        s = val(a) + val(b);
        tr = 1'b0; ov = 1'b0;
        if (s >= -16384 && s <= 16383) begin
            w = mk(1'b0, s);
        end else begin
            q = s >>> 5;
            r = s & 31;
            if (q > 16383) begin
                w = mk(1'b1, 16383); ov = 1'b1;
            end else if (q < -16384) begin
                w = mk(1'b1, -16384); ov = 1'b1;
            end else begin
                if (rnd && r >= 16 && q != 16383) q = q + 1;
                w = mk(1'b1, q);
                tr = (r != 0);
            end
        end
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One add: drive at a falling edge, sample at the next falling edge
    task automatic run_add(input string req, input logic [15:0] a, input logic [15:0] b,
                           input bit rnd);
        logic [15:0] ew; bit et, eo;
        model(a, b, rnd, ew, et, eo);
        @(negedge clk);
        op_a = a; op_b = b; round_en = rnd; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "result", int'(result), int'(ew));
        check(req, "trunc_flag", int'(trunc_flag), int'(et));
        check(req, "ovf_flag", int'(ovf_flag), int'(eo));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "result", int'(result), 0);
        check("R1", "flags", int'({trunc_flag, ovf_flag}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after release", int'(out_valid), 0);
    endtask

    task automatic t_fine_pairs();
        run_add("R4", mk(0, 100), mk(0, -30), 1'b0);
        run_add("R10", mk(0, 8000), mk(0, 8383), 1'b0);
        run_add("R10", mk(0, 16383), mk(0, 1), 1'b0);
        check("R10", "coarse sig 512", int'(result), int'(mk(1, 512)));
        run_add("R5", mk(0, 16383), mk(0, 16383), 1'b0);
        run_add("R7", mk(0, 16383), mk(0, 16383), 1'b1);
        check("R7", "rounded 1024", int'(result), int'(mk(1, 1024)));
        run_add("R4", mk(0, -16384), mk(0, 0), 1'b0);
    endtask

    task automatic t_mixed();
        run_add("R3", mk(1, -2), mk(0, 100), 1'b0);
        check("R3", "value 36", int'(result), int'(mk(0, 36)));
        run_add("R5", mk(1, 1000), mk(0, 7), 1'b0);
        run_add("R7", mk(1, 1000), mk(0, 7), 1'b1);
        run_add("R5", mk(1, -1000), mk(0, -7), 1'b0);
        check("R5", "floor -1001", int'(result), int'(mk(1, -1001)));
        run_add("R7", mk(1, -1000), mk(0, -7), 1'b1);
    endtask

    task automatic t_coarse_pairs();
        run_add("R6", mk(1, 600), mk(1, 700), 1'b1);
        run_add("R6", mk(1, 5), mk(1, -3), 1'b0);
        check("R6", "fine 64", int'(result), int'(mk(0, 64)));
    endtask

    task automatic t_limits();
        run_add("R8", mk(1, 16383), mk(0, 16), 1'b1);
        run_add("R9", mk(1, 16383), mk(1, 1), 1'b1);
        run_add("R9", mk(1, -16384), mk(1, -1), 1'b0);
        run_add("R9", mk(1, 16383), mk(1, 16383), 1'b0);
    endtask

    task automatic t_hold();
        logic [15:0] kept;
        run_add("R2", mk(1, 1234), mk(0, 3), 1'b0);
        kept = result;
        @(negedge clk);
        op_a = mk(0, 1); op_b = mk(0, 2);
        @(negedge clk);
        check("R2", "out_valid idle", int'(out_valid), 0);
        check("R2", "result held", int'(result), int'(kept));
        check("R2", "flags idle", int'({trunc_flag, ovf_flag}), 0);
    endtask

    initial begin
        t_reset();
        t_fine_pairs();
        t_mixed();
        t_coarse_pairs();
        t_limits();
        t_hold();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule